// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts the direction of a conditional branch by running two direction predictors side by side and letting a third table decide which one to trust. The first predictor tracks each branch on its own through a table of saturating counters that the low bits of the branch address select. The second predictor is indexed by the outcomes of the most recent branches, whichever branches they were. A chooser table, also indexed by low address bits, holds one 2-bit saturating counter per slot. That counter names the predictor whose answer becomes the final prediction.

A lookup is purely combinational. Given a branch address, the block returns the final direction, the answers of both predictors and the chooser's pick. When the branch resolves, the pipeline returns the address, the real outcome and the two predictor answers it received at lookup time. The block then trains both predictors on the outcome. It moves the chooser only when exactly one of the two predictors was right. Finally it shifts the outcome into the global history. A lookup and a resolve may occur in the same cycle, and the lookup sees the state from before that resolve.

Top module: `tourn_pred`

## Requirements
- R1: After reset every direction counter and every chooser counter holds 1 and the global history is zero. As a result, every lookup returns lk_local=0, lk_global=0, lk_use_global=0 and lk_taken=0.
- R2: lk_local is bit 1 of the local counter that PC bits [3:0] select. A value of 2 or 3 means taken.
- R3: lk_global is bit 1 of the global counter that the 4-bit history selects. History bit 0 holds the newest resolved outcome.
- R4: lk_use_global is 1 when the chooser counter at PC bits [3:0] is 2 or 3. lk_taken then equals lk_global; otherwise it equals lk_local.
- R5: On a resolve where rs_local differs from rs_global, the chooser counter at rs_pc[3:0] steps up by one (saturating at 3) if rs_global equals rs_taken, and steps down by one (saturating at 0) otherwise. When the two agree, the chooser holds.
- R6: A chooser at 3 or 0 needs two consecutive opposing updates before the pick changes. From the reset value of 1, a single global-correct update switches the pick to global.
- R7: On every resolve, whatever the chooser picked, the local counter at rs_pc[3:0] and the global counter at the current history both step toward the outcome. A taken outcome adds one, saturating at 3. A not-taken outcome subtracts one, saturating at 0.
- R8: The global counter update uses the history as it stood before the resolve. In the same cycle the history becomes {history[2:0], rs_taken}.
- R9: While rs_valid is 0, no counter and no history bit changes, whatever the other resolve inputs are.
- R10: A lookup made in the same cycle as a resolve reflects the state from before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Branch address being looked up |
| lk_taken | output | 1 | Final direction prediction |
| lk_local | output | 1 | Per-branch predictor's answer |
| lk_global | output | 1 | History-indexed predictor's answer |
| lk_use_global | output | 1 | 1 when the chooser picks the history-indexed predictor |
| rs_valid | input | 1 | A branch resolves this cycle |
| rs_pc | input | PC_W | Address of the resolving branch |
| rs_taken | input | 1 | Real outcome of the resolving branch |
| rs_local | input | 1 | Per-branch answer returned at its lookup |
| rs_global | input | 1 | History-indexed answer returned at its lookup |

## Verification
A wrong counter inside any of the three tables stays hidden until a lookup reaches that slot, or until the history selects that global entry. It then shows up at once as a flipped lk_local, lk_global or lk_use_global in that lookup cycle. A corrupted history bit shows up differently: it sends the very next lookup to the wrong global entry. Every later resolve then trains that wrong entry, so the error spreads over several cycles. The bench therefore compares all four lookup outputs against a reference model in every cycle, so that a bad state is reported within one lookup of the slot it affects. Directed sequences push the chooser through its saturation points and check the cycle in which the pick flips.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

   typedef enum logic {
      PICK_LOCAL  = 1'b0,
      PICK_GLOBAL = 1'b1
   } pick_e;

   typedef struct packed {
      logic  valid;
      logic  taken;
      logic  loc_ok;
      logic  glb_ok;
   } resolve_s;

endpackage

// File: rtl/sat_ctr_bank.sv
module sat_ctr_bank #(
   parameter int IDX_W = 4,
   parameter int CTR_W = 2,
   localparam int ENTRIES = 1 << IDX_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [IDX_W-1:0]                   rd_idx,
   output logic                               rd_hi,
   input  logic                               wr_en,
   input  logic [IDX_W-1:0]                   wr_idx,
   input  logic                               wr_up,
   output logic [ENTRIES-1:0][CTR_W-1:0]      state_o
);

   localparam logic [CTR_W-1:0] CTR_MAX  = {CTR_W{1'b1}};
   localparam logic [CTR_W-1:0] CTR_INIT = CTR_MAX >> 1;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_idx
      $error("sat_ctr_bank: IDX_W out of range");
   end
   if (CTR_W < 2 || CTR_W > 8) begin : g_bad_ctr
      $error("sat_ctr_bank: CTR_W out of range");
   end

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic hit;
      assign hit = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            state_o[i] <= CTR_INIT;
         end else if (hit) begin
            if (wr_up && state_o[i] != CTR_MAX) begin
               state_o[i] <= state_o[i] + 1'b1;
            end else if (!wr_up && state_o[i] != '0) begin
               state_o[i] <= state_o[i] - 1'b1;
            end
         end
      end
   end

   assign rd_hi = state_o[rd_idx][CTR_W-1];

endmodule

// File: rtl/ghist_reg.sv
module ghist_reg #(
   parameter int HIST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [HIST_W-1:0] hist_o
);

   if (HIST_W < 1 || HIST_W > 10) begin : g_bad_w
      $error("ghist_reg: HIST_W out of range");
   end

   if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (!rst_n)        hist_o <= '0;
         else if (shift_en) hist_o <= bit_in;
      end
   end else begin : g_many
      always_ff @(posedge clk) begin
         if (!rst_n)        hist_o <= '0;
         else if (shift_en) hist_o <= {hist_o[HIST_W-2:0], bit_in};
      end
   end

endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
   import tourn_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int LOC_IDX_W = 4,
   parameter int HIST_W    = 4,
   parameter int SEL_IDX_W = 4,
   parameter int DIR_CTR_W = 2,
   parameter int SEL_CTR_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_taken,
   output logic            lk_local,
   output logic            lk_global,
   output logic            lk_use_global,
   input  logic            rs_valid,
   input  logic [PC_W-1:0] rs_pc,
   input  logic            rs_taken,
   input  logic            rs_local,
   input  logic            rs_global
);

   localparam int LOC_N = 1 << LOC_IDX_W;
   localparam int GLB_N = 1 << HIST_W;
   localparam int SEL_N = 1 << SEL_IDX_W;

   if (LOC_IDX_W > PC_W || SEL_IDX_W > PC_W) begin : g_bad_pc
      $error("tourn_pred: index wider than PC");
   end

   logic [HIST_W-1:0]                     ghr;
   logic [LOC_N-1:0][DIR_CTR_W-1:0]       lctr_st;
   logic [GLB_N-1:0][DIR_CTR_W-1:0]       gctr_st;
   logic [SEL_N-1:0][SEL_CTR_W-1:0]       sel_st;
   logic                                  sel_hi;
   pick_e                                 pick;
   resolve_s                              rs;

   assign rs.valid  = rs_valid;
   assign rs.taken  = rs_taken;
   assign rs.loc_ok = (rs_local  == rs_taken);
   assign rs.glb_ok = (rs_global == rs_taken);

   sat_ctr_bank #(.IDX_W(LOC_IDX_W), .CTR_W(DIR_CTR_W)) u_local (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_pc[LOC_IDX_W-1:0]),
      .rd_hi   (lk_local),
      .wr_en   (rs.valid),
      .wr_idx  (rs_pc[LOC_IDX_W-1:0]),
      .wr_up   (rs.taken),
      .state_o (lctr_st)
   );

   sat_ctr_bank #(.IDX_W(HIST_W), .CTR_W(DIR_CTR_W)) u_global (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (ghr),
      .rd_hi   (lk_global),
      .wr_en   (rs.valid),
      .wr_idx  (ghr),
      .wr_up   (rs.taken),
      .state_o (gctr_st)
   );

   sat_ctr_bank #(.IDX_W(SEL_IDX_W), .CTR_W(SEL_CTR_W)) u_chooser (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_pc[SEL_IDX_W-1:0]),
      .rd_hi   (sel_hi),
      .wr_en   (rs.valid && (rs.loc_ok != rs.glb_ok)),
      .wr_idx  (rs_pc[SEL_IDX_W-1:0]),
      .wr_up   (rs.glb_ok),
      .state_o (sel_st)
   );

   ghist_reg #(.HIST_W(HIST_W)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (rs.valid),
      .bit_in   (rs.taken),
      .hist_o   (ghr)
   );

   assign pick          = sel_hi ? PICK_GLOBAL : PICK_LOCAL;
   assign lk_use_global = (pick == PICK_GLOBAL);
   assign lk_taken      = (pick == PICK_GLOBAL) ? lk_global : lk_local;

endmodule

// File: rtl/tourn_pred_chk.sv
module tourn_pred_chk #(
   parameter int PC_W      = 32,
   parameter int LOC_IDX_W = 4,
   parameter int HIST_W    = 4,
   parameter int SEL_IDX_W = 4,
   parameter int DIR_CTR_W = 2,
   parameter int SEL_CTR_W = 2,
   localparam int LOC_N = 1 << LOC_IDX_W,
   localparam int GLB_N = 1 << HIST_W,
   localparam int SEL_N = 1 << SEL_IDX_W
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            lk_taken,
   input logic                            lk_local,
   input logic                            lk_global,
   input logic                            lk_use_global,
   input logic                            rs_valid,
   input logic [PC_W-1:0]                 rs_pc,
   input logic                            rs_taken,
   input logic                            rs_local,
   input logic                            rs_global,
   input logic [HIST_W-1:0]               ghr,
   input logic [LOC_N-1:0][DIR_CTR_W-1:0] lctr_st,
   input logic [GLB_N-1:0][DIR_CTR_W-1:0] gctr_st,
   input logic [SEL_N-1:0][SEL_CTR_W-1:0] sel_st
);

   logic [SEL_IDX_W-1:0] sidx;
   logic [LOC_IDX_W-1:0] lidx;
   assign sidx = rs_pc[SEL_IDX_W-1:0];
   assign lidx = rs_pc[LOC_IDX_W-1:0];

   // R4: the final answer follows the picked component
   a_r4_follow_pick: assert property (@(posedge clk) disable iff (!rst_n)
      lk_taken == (lk_use_global ? lk_global : lk_local));

   // R9: an idle resolve port leaves all state untouched
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_valid |=> $stable(lctr_st) && $stable(gctr_st) && $stable(sel_st) && $stable(ghr));

   // R8: newest outcome enters history bit 0
   a_r8_hist_newest: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid |=> ghr[0] == $past(rs_taken));

   if (HIST_W > 1) begin : g_hist_chk
      // R8: older history bits move up by one
      a_r8_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
         rs_valid |=> ghr[HIST_W-1:1] == $past(ghr[HIST_W-2:0]));
   end

   // R5: agreement leaves every chooser counter alone
   a_r5_sel_agree_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid && (rs_local == rs_global) |=> $stable(sel_st));

   // R5: only-global-correct moves the chooser up unless saturated
   a_r5_sel_up: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid && (rs_global == rs_taken) && (rs_local != rs_taken) |=>
         (sel_st[$past(sidx)] >= $past(sel_st[sidx])) &&
         ((sel_st[$past(sidx)] != $past(sel_st[sidx])) || (&$past(sel_st[sidx]))));

   // R5: only-local-correct moves the chooser down unless saturated
   a_r5_sel_down: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid && (rs_local == rs_taken) && (rs_global != rs_taken) |=>
         (sel_st[$past(sidx)] <= $past(sel_st[sidx])) &&
         ((sel_st[$past(sidx)] != $past(sel_st[sidx])) || ($past(sel_st[sidx]) == '0)));

   // R7: a taken outcome never lowers the local counter
   a_r7_local_up: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid && rs_taken |=> lctr_st[$past(lidx)] >= $past(lctr_st[lidx]));

   // R7: a not-taken outcome never raises the global counter
   a_r7_global_down: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid && !rs_taken |=> gctr_st[$past(ghr)] <= $past(gctr_st[ghr]));

endmodule

bind tourn_pred tourn_pred_chk #(
   .PC_W(PC_W), .LOC_IDX_W(LOC_IDX_W), .HIST_W(HIST_W),
   .SEL_IDX_W(SEL_IDX_W), .DIR_CTR_W(DIR_CTR_W), .SEL_CTR_W(SEL_CTR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .lk_taken(lk_taken), .lk_local(lk_local), .lk_global(lk_global),
   .lk_use_global(lk_use_global),
   .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
   .rs_local(rs_local), .rs_global(rs_global),
   .ghr(ghr), .lctr_st(lctr_st), .gctr_st(gctr_st), .sel_st(sel_st)
);

// File: tb/sim_tourn_pred.sv
module sim_tourn_pred;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_taken, lk_local, lk_global, lk_use_global;
   logic        rs_valid = 1'b0;
   logic [31:0] rs_pc = '0;
   logic        rs_taken = 1'b0;
   logic        rs_local = 1'b0;
   logic        rs_global = 1'b0;

   int checks = 0;
   int errors = 0;

   int mloc [16];
   int mglb [16];
   int msel [16];
   int mhist;

   always #(CLK_PERIOD/2) clk = ~clk;

   tourn_pred u0 (
      .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
      .lk_taken(lk_taken), .lk_local(lk_local), .lk_global(lk_global),
      .lk_use_global(lk_use_global),
      .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
      .rs_local(rs_local), .rs_global(rs_global)
   );

   function automatic int sat_move(input int v, input bit up);
      if (up) return (v == 3) ? 3 : v + 1;
      return (v == 0) ? 0 : v - 1;
   endfunction

   function automatic bit hi(input int v);
      return v >= 2;
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 16; i++) begin
         mloc[i] = 1; mglb[i] = 1; msel[i] = 1;
      end
      mhist = 0;
   endtask

   // One cycle: lookup at pc, checked before the edge, then an optional resolve.
   task automatic step(input string req, input logic [31:0] pc, input bit vld,
                       input bit tk, input bit ovr, input bit ol, input bit og);
      int  li;
      bit  el, eg, eu;
      @(negedge clk);
      li = int'(pc[3:0]);
      el = hi(mloc[li]);
      eg = hi(mglb[mhist]);
      eu = hi(msel[li]);
      lk_pc    = pc;
      rs_pc    = pc;
      rs_valid = vld;
      rs_taken = tk;
      rs_local  = ovr ? ol : el;
      rs_global = ovr ? og : eg;
      #1;
      chk({req, " R2 lk_local"}, lk_local, el);
      chk({req, " R3 lk_global"}, lk_global, eg);
      chk({req, " R4 lk_use_global"}, lk_use_global, eu);
      chk({req, " R4 lk_taken"}, lk_taken, eu ? eg : el);
      @(posedge clk);
      if (vld) begin
         if (rs_local != rs_global)
            msel[li] = sat_move(msel[li], rs_global == tk);
         mloc[li]    = sat_move(mloc[li], tk);
         mglb[mhist] = sat_move(mglb[mhist], tk);
         mhist       = ((mhist << 1) | int'(tk)) & 15;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values seen through lookups at every slot
      for (int p = 0; p < 16; p++) begin
         @(negedge clk);
         lk_pc = 32'(p) | 32'h4000_0000;
         #1;
         chk("R1 reset lk_local",      lk_local,      1'b0);
         chk("R1 reset lk_global",     lk_global,     1'b0);
         chk("R1 reset lk_use_global", lk_use_global, 1'b0);
         chk("R1 reset lk_taken",      lk_taken,      1'b0);
      end

      // R9: idle resolve port with busy data changes nothing
      for (int k = 0; k < 20; k++)
         step("R9 idle", $urandom, 1'b0, 1'($urandom), 1'b1, 1'($urandom), 1'($urandom));
      for (int p = 0; p < 16; p++)
         step("R9 after-idle", 32'(p), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // R6: chooser at slot 5 from reset value 1
      step("R6 g-right", 32'h5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1); // 1->2
      step("R6 flip-to-global", 32'h5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R6 pick global after one update", lk_use_global, 1'b1);
      step("R6 l-right", 32'h5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // 2->1
      step("R6 back-local", 32'h5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R6 pick local again", lk_use_global, 1'b0);
      step("R5 g-right", 32'h5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // 1->2
      step("R5 g-right", 32'h5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // 2->3
      step("R5 g-right sat", 32'h5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // 3
      step("R5 agree hold", 32'h5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // hold
      step("R6 l-right once", 32'h5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // 3->2
      step("R6 still-global", 32'h5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R6 strong chooser survives one miss", lk_use_global, 1'b1);
      step("R6 l-right twice", 32'h5, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // 2->1
      step("R6 now-local", 32'h5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R6 flips after two misses", lk_use_global, 1'b0);

      // R7: saturation of local counter at slot 9 both ways
      for (int k = 0; k < 5; k++)
         step("R7 taken-run", 32'h9, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k < 5; k++)
         step("R7 not-taken-run", 32'h9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

      // R8: history pattern 1010 steers global index
      step("R8 h", 32'h1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      step("R8 h", 32'h2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      step("R8 h", 32'h3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      step("R8 h", 32'h4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

      // R10 with R5/R7/R8: random traffic, lookup and resolve share a cycle
      for (int k = 0; k < 600; k++) begin
         logic [31:0] pc;
         bit tk, vld, ovr;
         pc  = $urandom;
         pc[31:4] = ($urandom % 4 == 0) ? pc[31:4] : 28'h0;
         pc[3:0]  = ($urandom % 2 == 0) ? 4'(pc[1:0]) : pc[3:0];
         tk  = ($urandom % 4) != 0;
         vld = ($urandom % 8) != 0;
         ovr = ($urandom % 5) == 0;
         step("R10 random", pc, vld, tk, ovr, 1'($urandom), 1'($urandom));
      end

      // R1: reset again mid-run returns every slot to the initial answers
      @(negedge clk);
      rst_n = 1'b0;
      rs_valid = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      for (int p = 0; p < 16; p++)
         step("R1 re-reset", 32'(p), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule